// File: doc/BRIEF.md
# Direct-Mapped Address Translation Unit

This block turns a 32-bit virtual address into a physical address through two direct-mapped translation tables: one serves instruction fetches and the other serves data loads and stores. Each table entry is a pair of words. The tag word holds a page-number tag and a valid flag. The frame word holds a physical page frame and the access rights. A lookup is strobed with `req`. One cycle later the block returns either the translated address or a fault cause. The fault cause comes with one of four single-cycle exception pulses. The virtual address of any faulting lookup is held in `fault_addr` for the exception handler.

Software or refill logic loads the tables through a plain write port. Each write picks a table, an index, a word within the entry, and a 32-bit value. When translation is switched off, every access passes through unchanged and is always permitted.

Top module: `tlb_xlate`

## Requirements
- R1: Reset clears `rsp_valid`, `rsp_cause`, all exception outputs, `fault_addr` and every table word, so a translated lookup after reset misses unless its page number is 0.
- R2: Each cycle in which `req` is high produces one cycle of `rsp_valid` at the next clock edge. `rsp_valid` is low when there was no request in the previous cycle.
- R3: While `xlate_en` is low, `rsp_paddr` equals the virtual address and `rsp_cause` is 0 for any fetch, read or write in either mode.
- R4: The page number is `vaddr[31:13]`, and the table index is its low 6 bits. If bits [31:13] of the indexed tag word differ from the page number, `rsp_cause` is 1. The lookup then raises `exc_itlb_miss` for a fetch (`req_fetch`=1) or `exc_dtlb_miss` for a data access.
- R5: A tag match on an entry whose tag-word bit 0 (valid) is clear gives `rsp_cause` 2, which is a page fault.
- R6: A fetch is allowed only when frame-word bit 2 is set in supervisor mode (`req_super`=1), or frame-word bit 1 is set in user mode. Otherwise `rsp_cause` is 2 with `exc_ipf`.
- R7: A data read needs frame-word bit 3 in supervisor mode or bit 1 in user mode. A data write (`req_write`=1) needs bit 4 in supervisor mode or bit 2 in user mode. Otherwise `rsp_cause` is 2 with `exc_dpf`.
- R8: On a successful translated lookup, `rsp_paddr` is frame-word bits [31:13] joined with `vaddr[12:0]`. On a fault, `rsp_paddr` is 0.
- R9: On every fault, `fault_addr` captures the virtual address of that lookup. Lookups without a fault leave it unchanged.
- R10: The write port selects the table with `wr_side` (1 is instruction, 0 is data) and the word with `wr_word` (0 is tag, 1 is frame). A write in the same cycle as a lookup to that index is seen only by later lookups.
- R11: The exception outputs are at most one-hot and last one cycle. A miss exception appears only with cause 1, and a page-fault exception only with cause 2.
- R12: The two tables are separate: entries written to one table are never used by lookups of the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Lookup strobe |
| req_fetch | input | 1 | 1 for instruction fetch, 0 for data access |
| req_write | input | 1 | 1 for data write, 0 for read (data side only) |
| req_super | input | 1 | 1 for supervisor mode, 0 for user mode |
| xlate_en | input | 1 | Translation enable; 0 selects pass-through |
| vaddr | input | 32 | Virtual address |
| wr_en | input | 1 | Table write strobe |
| wr_side | input | 1 | 1 for instruction table, 0 for data table |
| wr_word | input | 1 | 0 for tag word, 1 for frame word |
| wr_idx | input | 6 | Entry index |
| wr_data | input | 32 | Value to write |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_cause | output | 2 | 0 for success, 1 for miss, 2 for page fault |
| exc_itlb_miss | output | 1 | Instruction-side miss exception |
| exc_dtlb_miss | output | 1 | Data-side miss exception |
| exc_ipf | output | 1 | Instruction page fault exception |
| exc_dpf | output | 1 | Data page fault exception |
| fault_addr | output | 32 | Virtual address of the last fault |

## Verification
A table write and a lookup can land on the same entry in the same clock edge. The bench provokes this by strobing a data lookup while writing the tag word that would make it hit. The lookup must still report a miss, and an identical lookup issued on the next cycle must return the translated address. A second overlap is a fault arriving while `fault_addr` already holds an earlier address. The new address must replace the old one, and a following clean hit must leave it untouched.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int AW      = 32,
  parameter int OFFW    = 13,
  parameter int ENTRIES = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req,
  input  logic                        req_fetch,
  input  logic                        req_write,
  input  logic                        req_super,
  input  logic                        xlate_en,
  input  logic [AW-1:0]               vaddr,
  input  logic                        wr_en,
  input  logic                        wr_side,
  input  logic                        wr_word,
  input  logic [$clog2(ENTRIES)-1:0]  wr_idx,
  input  logic [AW-1:0]               wr_data,
  output logic                        rsp_valid,
  output logic [AW-1:0]               rsp_paddr,
  output logic [1:0]                  rsp_cause,
  output logic                        exc_itlb_miss,
  output logic                        exc_dtlb_miss,
  output logic                        exc_ipf,
  output logic                        exc_dpf,
  output logic [AW-1:0]               fault_addr
);
  localparam int IDXW = $clog2(ENTRIES);
  localparam int VPNW = AW - OFFW;
  localparam int B_UX = 1, B_SX = 2;
  localparam int B_UR = 1, B_UW = 2, B_SR = 3, B_SW = 4;
  localparam logic [1:0] C_OK = 2'd0, C_MISS = 2'd1, C_PF = 2'd2;

  logic [AW-1:0] itag [ENTRIES];
  logic [AW-1:0] ifrm [ENTRIES];
  logic [AW-1:0] dtag [ENTRIES];
  logic [AW-1:0] dfrm [ENTRIES];

  logic [VPNW-1:0] vpn;
  logic [IDXW-1:0] idx;
  logic [AW-1:0]   tword, fword;
  logic            tag_hit, allow;
  logic [1:0]      cause_n;
  logic [AW-1:0]   paddr_n;
  logic            unused_bits;

  assign vpn     = vaddr[AW-1:OFFW];
  assign idx     = vpn[IDXW-1:0];
  assign tword   = req_fetch ? itag[idx] : dtag[idx];
  assign fword   = req_fetch ? ifrm[idx] : dfrm[idx];
  assign tag_hit = (tword[AW-1:OFFW] == vpn);

  always_comb begin
    if (req_fetch)      allow = req_super ? fword[B_SX] : fword[B_UX];
    else if (req_write) allow = req_super ? fword[B_SW] : fword[B_UW];
    else                allow = req_super ? fword[B_SR] : fword[B_UR];
  end

  assign cause_n = !xlate_en ? C_OK :
                   !tag_hit  ? C_MISS :
                   (!tword[0] || !allow) ? C_PF : C_OK;

  assign paddr_n = !xlate_en       ? vaddr :
                   (cause_n != C_OK) ? '0 :
                   {fword[AW-1:OFFW], vaddr[OFFW-1:0]};

  assign unused_bits = ^{fword[OFFW-1:0], tword[OFFW-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        itag[i] <= '0;
        ifrm[i] <= '0;
        dtag[i] <= '0;
        dfrm[i] <= '0;
      end
    end else if (wr_en) begin
      case ({wr_side, wr_word})
        2'b00: dtag[wr_idx] <= wr_data;
        2'b01: dfrm[wr_idx] <= wr_data;
        2'b10: itag[wr_idx] <= wr_data;
        default: ifrm[wr_idx] <= wr_data;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_cause     <= C_OK;
      exc_itlb_miss <= 1'b0;
      exc_dtlb_miss <= 1'b0;
      exc_ipf       <= 1'b0;
      exc_dpf       <= 1'b0;
      fault_addr    <= '0;
    end else begin
      rsp_valid     <= req;
      rsp_paddr     <= req ? paddr_n : '0;
      rsp_cause     <= req ? cause_n : C_OK;
      exc_itlb_miss <= req &&  req_fetch && (cause_n == C_MISS);
      exc_dtlb_miss <= req && !req_fetch && (cause_n == C_MISS);
      exc_ipf       <= req &&  req_fetch && (cause_n == C_PF);
      exc_dpf       <= req && !req_fetch && (cause_n == C_PF);
      if (req && cause_n != C_OK) fault_addr <= vaddr;
    end
  end

  a_r11_exc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_itlb_miss, exc_dtlb_miss, exc_ipf, exc_dpf}));

  a_r11_miss_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_itlb_miss || exc_dtlb_miss) |-> (rsp_valid && rsp_cause == C_MISS));

  a_r11_pf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ipf || exc_dpf) |-> (rsp_valid && rsp_cause == C_PF));

  a_r2_no_req_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !rsp_valid);

  a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !xlate_en) |=> (rsp_cause == C_OK && rsp_paddr == $past(vaddr)));

  a_r8_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (req && xlate_en) |=> (rsp_cause != C_OK || rsp_paddr[OFFW-1:0] == $past(vaddr[OFFW-1:0])));

  a_r9_fault_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause != C_OK) |-> (fault_addr == $past(vaddr)));

  a_r9_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(fault_addr));
endmodule

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, req_fetch, req_write, req_super, xlate_en;
  logic [31:0] vaddr;
  logic        wr_en, wr_side, wr_word;
  logic [5:0]  wr_idx;
  logic [31:0] wr_data;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_cause;
  logic        exc_itlb_miss, exc_dtlb_miss, exc_ipf, exc_dpf;
  logic [31:0] fault_addr;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_fa = 32'h0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tlb_xlate i_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .req(req), .req_fetch(req_fetch),
    .req_write(req_write), .req_super(req_super), .xlate_en(xlate_en),
    .vaddr(vaddr), .wr_en(wr_en), .wr_side(wr_side), .wr_word(wr_word),
    .wr_idx(wr_idx), .wr_data(wr_data), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_cause(rsp_cause),
    .exc_itlb_miss(exc_itlb_miss), .exc_dtlb_miss(exc_dtlb_miss),
    .exc_ipf(exc_ipf), .exc_dpf(exc_dpf), .fault_addr(fault_addr)
  );

  // {fetch, write, super, xlate, vaddr, cause, paddr}
  localparam int NV = 18;
  localparam logic [69:0] VEC [NV] = '{
    {1'b1,1'b0,1'b1,1'b1,32'h00002ABC,2'd0,32'h00ABCABC}, // R6 R8 super exec
    {1'b1,1'b0,1'b0,1'b1,32'h00002ABC,2'd2,32'h00000000}, // R6 no user exec
    {1'b1,1'b0,1'b0,1'b1,32'h00005123,2'd0,32'h12347123}, // R6 user exec
    {1'b1,1'b0,1'b1,1'b1,32'h00005123,2'd2,32'h00000000}, // R6 no super exec
    {1'b1,1'b0,1'b1,1'b1,32'h00006010,2'd2,32'h00000000}, // R5 invalid
    {1'b1,1'b0,1'b1,1'b1,32'h00082ABC,2'd1,32'h00000000}, // R4 alias miss
    {1'b0,1'b0,1'b0,1'b1,32'h0000A444,2'd0,32'h0ABC0444}, // R7 user read
    {1'b0,1'b1,1'b0,1'b1,32'h0000A444,2'd2,32'h00000000}, // R7 no user write
    {1'b0,1'b1,1'b1,1'b1,32'h0000BFFF,2'd0,32'h0ABC1FFF}, // R7 R8 super write
    {1'b0,1'b0,1'b0,1'b1,32'h0000C008,2'd2,32'h00000000}, // R7 no user read
    {1'b0,1'b1,1'b0,1'b1,32'h0000C008,2'd0,32'h0F000008}, // R7 user write
    {1'b0,1'b0,1'b1,1'b1,32'h0000C008,2'd0,32'h0F000008}, // R7 super read
    {1'b0,1'b1,1'b1,1'b1,32'h0000C008,2'd2,32'h00000000}, // R7 no super write
    {1'b0,1'b0,1'b1,1'b1,32'h00002000,2'd1,32'h00000000}, // R4 R12 data miss
    {1'b1,1'b0,1'b0,1'b0,32'hDEADBEEF,2'd0,32'hDEADBEEF}, // R3 bypass fetch
    {1'b0,1'b1,1'b0,1'b0,32'h00006010,2'd0,32'h00006010}, // R3 bypass write
    {1'b0,1'b0,1'b1,1'b1,32'h00000010,2'd2,32'h00000000}, // R5 reset entry 0
    {1'b1,1'b0,1'b1,1'b1,32'h0000A444,2'd1,32'h00000000}  // R12 fetch miss
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic side, input logic word, input logic [5:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_side = side; wr_word = word; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic f, input logic w, input logic s, input logic x, input logic [31:0] va);
    @(negedge clk);
    req = 1'b1; req_fetch = f; req_write = w; req_super = s; xlate_en = x; vaddr = va;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input logic f, input logic [31:0] va,
                            input logic [1:0] c, input logic [31:0] pa);
    logic [3:0] exc_exp;
    exc_exp = {f && c == 2'd1, !f && c == 2'd1, f && c == 2'd2, !f && c == 2'd2};
    if (c != 2'd0) exp_fa = va;
    check({tag, " valid"}, {31'b0, rsp_valid}, 32'h1);
    check({tag, " cause"}, {30'b0, rsp_cause}, {30'b0, c});
    check({tag, " paddr"}, rsp_paddr, pa);
    check({tag, " exc"}, {28'b0, exc_itlb_miss, exc_dtlb_miss, exc_ipf, exc_dpf}, {28'b0, exc_exp});
    check({tag, " fault_addr"}, fault_addr, exp_fa);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; req_fetch = 1'b0; req_write = 1'b0; req_super = 1'b0;
    xlate_en = 1'b1; vaddr = '0; wr_en = 1'b0; wr_side = 1'b0; wr_word = 1'b0;
    wr_idx = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid", {31'b0, rsp_valid}, 32'h0);
    check("R1 cause", {30'b0, rsp_cause}, 32'h0);
    check("R1 exc", {28'b0, exc_itlb_miss, exc_dtlb_miss, exc_ipf, exc_dpf}, 32'h0);
    check("R1 fault_addr", fault_addr, 32'h0);

    // R10 table loading
    wr(1'b1, 1'b0, 6'd1, 32'h00002001);
    wr(1'b1, 1'b1, 6'd1, 32'h00ABC004);
    wr(1'b1, 1'b0, 6'd2, 32'h00004001);
    wr(1'b1, 1'b1, 6'd2, 32'h12346002);
    wr(1'b1, 1'b0, 6'd3, 32'h00006000);
    wr(1'b1, 1'b1, 6'd3, 32'h00002006);
    wr(1'b0, 1'b0, 6'd5, 32'h0000A001);
    wr(1'b0, 1'b1, 6'd5, 32'h0ABC001A);
    wr(1'b0, 1'b0, 6'd6, 32'h0000C001);
    wr(1'b0, 1'b1, 6'd6, 32'h0F00000C);

    for (int k = 0; k < NV; k++) begin
      look(VEC[k][69], VEC[k][68], VEC[k][67], VEC[k][66], VEC[k][65:34]);
      expect_rsp($sformatf("vec%0d", k), VEC[k][69], VEC[k][65:34], VEC[k][33:32], VEC[k][31:0]);
    end

    // R2 R11: response and exceptions last one cycle
    look(1'b1, 1'b0, 1'b0, 1'b1, 32'h00002ABC);
    expect_rsp("R6 pulse", 1'b1, 32'h00002ABC, 2'd2, 32'h0);
    @(negedge clk);
    check("R2 valid drop", {31'b0, rsp_valid}, 32'h0);
    check("R11 exc drop", {28'b0, exc_itlb_miss, exc_dtlb_miss, exc_ipf, exc_dpf}, 32'h0);

    // R9: a clean hit keeps the captured fault address
    look(1'b1, 1'b0, 1'b0, 1'b1, 32'h00005123);
    expect_rsp("R9 hold", 1'b1, 32'h00005123, 2'd0, 32'h12347123);

    // R10: rewrite an entry, now user exec allowed
    wr(1'b1, 1'b1, 6'd1, 32'h00ABC002);
    look(1'b1, 1'b0, 1'b0, 1'b1, 32'h00003001);
    expect_rsp("R10 rewrite", 1'b1, 32'h00003001, 2'd0, 32'h00ABD001);

    // R10: write and lookup in the same cycle
    wr(1'b0, 1'b1, 6'd7, 32'h05550002);
    @(negedge clk);
    req = 1'b1; req_fetch = 1'b0; req_write = 1'b0; req_super = 1'b0; xlate_en = 1'b1;
    vaddr = 32'h0000E0F0;
    wr_en = 1'b1; wr_side = 1'b0; wr_word = 1'b0; wr_idx = 6'd7; wr_data = 32'h0000E001;
    @(negedge clk);
    wr_en = 1'b0;
    expect_rsp("R10 same-cycle old", 1'b0, 32'h0000E0F0, 2'd1, 32'h0);
    @(negedge clk);
    req = 1'b0;
    expect_rsp("R10 same-cycle new", 1'b0, 32'h0000E0F0, 2'd0, 32'h055500F0);

    // R1: reset clears the tables and fault register
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    exp_fa = 32'h0;
    check("R1 fault_addr clear", fault_addr, 32'h0);
    look(1'b1, 1'b0, 1'b1, 1'b1, 32'h00002ABC);
    expect_rsp("R1 table clear", 1'b1, 32'h00002ABC, 2'd1, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule